// File: doc/BRIEF.md
# Processor Interrupt Level Resolver

This block sits beside a processor core and decides whether a level interrupt must be signalled to it. It combines a 16-bit vector of external interrupt levels with the core's software-interrupt register. It then finds the highest pending level that lies above the core's current priority. That level is turned into an external-interrupt trap type, which is presented together with a hard-interrupt request line.

Several conditions change what the resolver does:
- A pending vectored interrupt takes precedence over every level, so while it is pending the resolver freezes.
- A global enable gates new requests.
- If the core is already inside an external-interrupt trap of higher type at a nonzero trap level, re-raising is suppressed.
- Both timer-match bits of the software-interrupt register are reported as level 14.

The decision is re-evaluated every clock. The request and trap type are registered, so each reflects the inputs of the previous cycle.

Top module: `irl_resolver`

## Requirements
- R1: While rst_ni is low, irq_req_o is 0 and irq_tt_o is 0.
- R2: Pending level i (1..15) is set when lvl_req_i[i] or softint_i[i] is 1. softint_i[0] (tick match) and softint_i[16] (system-tick match) never count as their own level.
- R3: When softint_i[0] or softint_i[16] is 1, level 14 counts as pending.
- R4: While ivec_busy_i is 1, irq_req_o and irq_tt_o keep their values at the next edge.
- R5: With ivec_busy_i low and no pending level strictly above pil_i, an asserted request is cleared and irq_tt_o becomes 0 at the next edge. pil_i = 15 therefore always clears.
- R6: With ivec_busy_i low, int_en_i high and a pending level above pil_i, the highest such level L is selected. After the next edge irq_tt_o = 0x40 | L (0x41..0x4F) and irq_req_o = 1.
- R7: The new type is not raised when all of the following hold: tl_i is nonzero, cur_tt_i[8:4] equals 0x4 (the external-interrupt class), and cur_tt_i is greater than the new type. In that case the outputs hold.
- R8: The outputs change only when the selected type differs from the stored irq_tt_o. A higher level that appears while a request is outstanding replaces the stored type, and the request stays at 1.
- R9: With ivec_busy_i low, int_en_i low and a request outstanding, the request is cleared and irq_tt_o becomes 0 at the next edge.
- R10: irq_req_o = 0 always implies irq_tt_o = 0, and irq_req_o = 1 always implies irq_tt_o is in 0x41..0x4F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lvl_req_i | input | 16 | External interrupt level vector, bit i = level i |
| softint_i | input | 17 | Software-interrupt register: bit 0 tick match, bits 1..15 levels, bit 16 system-tick match |
| pil_i | input | 4 | Current processor interrupt priority |
| int_en_i | input | 1 | Global interrupt enable |
| ivec_busy_i | input | 1 | Vectored interrupt pending |
| tl_i | input | 3 | Current trap level |
| cur_tt_i | input | 9 | Trap type currently being serviced |
| irq_req_o | output | 1 | Hard-interrupt request |
| irq_tt_o | output | 9 | Selected trap type |

## Verification
Every result of this block is due exactly one rising edge after the inputs that produce it. The bench drives all inputs on a falling edge. It then waits through one rising edge and samples on the following falling edge. The expected request and trap type come from a bench model that is advanced once per step.

Directed steps cover several cases: each software timer bit alone, level selection against the priority field, the frozen outputs under a vectored interrupt, nested suppression, and the two clearing paths. A seeded random phase then mixes all of these.

// File: rtl/irl_pkg.sv
package irl_pkg;
  localparam int unsigned TT_W       = 9;
  localparam logic [8:0]  EXT_BASE   = 9'h040;
  localparam logic [8:0]  CLASS_MASK = 9'h1F0;
  localparam int unsigned TIMER_LVL  = 14;
endpackage

// File: rtl/irl_pending_merge.sv
module irl_pending_merge #(
  parameter int unsigned LVL_N     = 16,
  parameter int unsigned SOFT_W    = 17,
  parameter int unsigned TICK_BIT  = 0,
  parameter int unsigned STICK_BIT = 16,
  parameter int unsigned TIMER_LVL = 14
) (
  input  logic [LVL_N-1:0]  lvl_req_i,
  input  logic [SOFT_W-1:0] softint_i,
  output logic [LVL_N-1:0]  pend_o
);
  logic timer_hit;
  assign timer_hit = softint_i[TICK_BIT] | softint_i[STICK_BIT];

  for (genvar i = 0; i < LVL_N; i++) begin : g_bit
    localparam bit IS_TMR = (i == TICK_BIT) || (i == STICK_BIT);
    localparam bit IS_TLV = (i == TIMER_LVL);
    logic soft_b;
    if (IS_TMR) begin : g_tmr
      assign soft_b = 1'b0;
    end else begin : g_lvl
      assign soft_b = softint_i[i];
    end
    if (IS_TLV) begin : g_tlv
      assign pend_o[i] = lvl_req_i[i] | soft_b | timer_hit;
    end else begin : g_plain
      assign pend_o[i] = lvl_req_i[i] | soft_b;
    end
  end
endmodule

// File: rtl/irl_level_pick.sv
module irl_level_pick #(
  parameter int unsigned LVL_N = 16,
  localparam int unsigned PIL_W = $clog2(LVL_N)
) (
  input  logic [LVL_N-1:0] pend_i,
  input  logic [PIL_W-1:0] pil_i,
  output logic             any_o,
  output logic [PIL_W-1:0] lvl_o
);
  logic [LVL_N-1:0] above;
  logic [LVL_N-1:0] hit;

  for (genvar i = 0; i < LVL_N; i++) begin : g_mask
    assign above[i] = (PIL_W'(i) > pil_i);
  end
  assign hit   = pend_i & above;
  assign any_o = |hit;

  // ascending scan, last hit wins => highest level
  always_comb begin
    lvl_o = '0;
    for (int i = 0; i < LVL_N; i++) begin
      if (hit[i]) lvl_o = PIL_W'(i);
    end
  end
endmodule

// File: rtl/irl_ctrl.sv
module irl_ctrl
  import irl_pkg::*;
#(
  parameter int unsigned TL_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            any_i,
  input  logic [TT_W-1:0] new_tt_i,
  input  logic            int_en_i,
  input  logic            ivec_busy_i,
  input  logic [TL_W-1:0] tl_i,
  input  logic [TT_W-1:0] cur_tt_i,
  output logic            req_o,
  output logic [TT_W-1:0] tt_o
);
  logic            req_q, req_d;
  logic [TT_W-1:0] tt_q, tt_d;
  logic            nested_blk;

  assign nested_blk = (tl_i != '0) && (cur_tt_i > new_tt_i) &&
                      ((cur_tt_i & CLASS_MASK) == EXT_BASE);

  always_comb begin
    req_d = req_q;
    tt_d  = tt_q;
    if (!ivec_busy_i) begin
      if (!any_i) begin
        if (req_q) begin
          req_d = 1'b0;
          tt_d  = '0;
        end
      end else if (int_en_i) begin
        if (!nested_blk && (new_tt_i != tt_q)) begin
          req_d = 1'b1;
          tt_d  = new_tt_i;
        end
      end else if (req_q) begin
        req_d = 1'b0;
        tt_d  = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      tt_q  <= '0;
    end else begin
      req_q <= req_d;
      tt_q  <= tt_d;
    end
  end

  assign req_o = req_q;
  assign tt_o  = tt_q;
endmodule

// File: rtl/irl_resolver.sv
module irl_resolver
  import irl_pkg::*;
#(
  parameter int unsigned LVL_N     = 16,
  parameter int unsigned SOFT_W    = 17,
  parameter int unsigned TICK_BIT  = 0,
  parameter int unsigned STICK_BIT = 16,
  parameter int unsigned TL_W      = 3,
  localparam int unsigned PIL_W    = $clog2(LVL_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LVL_N-1:0]  lvl_req_i,
  input  logic [SOFT_W-1:0] softint_i,
  input  logic [PIL_W-1:0]  pil_i,
  input  logic              int_en_i,
  input  logic              ivec_busy_i,
  input  logic [TL_W-1:0]   tl_i,
  input  logic [TT_W-1:0]   cur_tt_i,
  output logic              irq_req_o,
  output logic [TT_W-1:0]   irq_tt_o
);
  logic [LVL_N-1:0] pend;
  logic             any;
  logic [PIL_W-1:0] lvl;
  logic [TT_W-1:0]  new_tt;

  irl_pending_merge #(
    .LVL_N(LVL_N), .SOFT_W(SOFT_W), .TICK_BIT(TICK_BIT),
    .STICK_BIT(STICK_BIT), .TIMER_LVL(TIMER_LVL)
  ) u_merge (
    .lvl_req_i(lvl_req_i), .softint_i(softint_i), .pend_o(pend)
  );

  irl_level_pick #(.LVL_N(LVL_N)) u_pick (
    .pend_i(pend), .pil_i(pil_i), .any_o(any), .lvl_o(lvl)
  );

  assign new_tt = EXT_BASE | TT_W'(lvl);

  irl_ctrl #(.TL_W(TL_W)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .any_i(any), .new_tt_i(new_tt),
    .int_en_i(int_en_i), .ivec_busy_i(ivec_busy_i), .tl_i(tl_i),
    .cur_tt_i(cur_tt_i), .req_o(irq_req_o), .tt_o(irq_tt_o)
  );
endmodule

// File: rtl/irl_resolver_chk.sv
module irl_resolver_chk
  import irl_pkg::*;
#(
  parameter int unsigned LVL_N  = 16,
  parameter int unsigned SOFT_W = 17,
  parameter int unsigned TL_W   = 3,
  localparam int unsigned PIL_W = $clog2(LVL_N)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [LVL_N-1:0]  lvl_req_i,
  input logic [SOFT_W-1:0] softint_i,
  input logic [PIL_W-1:0]  pil_i,
  input logic              int_en_i,
  input logic              ivec_busy_i,
  input logic [TL_W-1:0]   tl_i,
  input logic [TT_W-1:0]   cur_tt_i,
  input logic              irq_req_o,
  input logic [TT_W-1:0]   irq_tt_o
);
  localparam logic [TT_W-1:0] TOP_TT = EXT_BASE | TT_W'(LVL_N - 1);

  always_comb begin
    if (!rst_ni) assert_reset_clear_R1: assert (!irq_req_o && irq_tt_o == '0);
  end

  assert_busy_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ivec_busy_i |=> ($stable(irq_req_o) && $stable(irq_tt_o)));

  assert_top_pil_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ivec_busy_i && pil_i == '1) |=> (!irq_req_o && irq_tt_o == '0));

  assert_nested_block_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ivec_busy_i && tl_i != '0 && cur_tt_i == TOP_TT && !lvl_req_i[LVL_N-1] &&
     !softint_i[LVL_N-1] && !irq_req_o) |=> !irq_req_o);

  assert_disabled_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ivec_busy_i && !int_en_i && irq_req_o) |=> (!irq_req_o && irq_tt_o == '0));

  assert_idle_tt_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_req_o |-> irq_tt_o == '0);

  assert_tt_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> ((irq_tt_o & CLASS_MASK) == EXT_BASE && irq_tt_o != EXT_BASE));

  assert_rise_needs_free_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_req_o) |-> ($past(!ivec_busy_i) && $past(int_en_i)));
endmodule

bind irl_resolver irl_resolver_chk #(
  .LVL_N(LVL_N), .SOFT_W(SOFT_W), .TL_W(TL_W)
) u_chk (.*);

// File: tb/irl_resolver_tb.sv
module irl_resolver_tb;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] lvl_req = '0;
  logic [16:0] softint = '0;
  logic [3:0]  pil = '0;
  logic        int_en = 1'b0;
  logic        busy = 1'b0;
  logic [2:0]  tl = '0;
  logic [8:0]  cur_tt = '0;
  logic        req;
  logic [8:0]  tt;

  int n_chk = 0;
  int n_fail = 0;
  logic       m_req = 1'b0;
  logic [8:0] m_tt = '0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irl_resolver u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .lvl_req_i(lvl_req), .softint_i(softint),
    .pil_i(pil), .int_en_i(int_en), .ivec_busy_i(busy), .tl_i(tl),
    .cur_tt_i(cur_tt), .irq_req_o(req), .irq_tt_o(tt)
  );

  function automatic logic [15:0] pend_of(logic [15:0] l, logic [16:0] s);
    logic [15:0] p;
    p = l | (s[15:0] & 16'hFFFE);
    if (s[0] || s[16]) p[14] = 1'b1;
    return p;
  endfunction

  // model: updates m_req/m_tt for one edge
  task automatic model_step();
    logic [15:0] p;
    int lv;
    logic [8:0] nt;
    p  = pend_of(lvl_req, softint);
    lv = -1;
    for (int i = 15; i > int'(pil); i--) if (lv < 0 && p[i]) lv = i;
    if (busy) return;
    if (lv < 0) begin
      if (m_req) begin m_req = 1'b0; m_tt = '0; end
    end else if (int_en) begin
      nt = 9'h040 | 9'(lv);
      if (!(tl != 0 && cur_tt > nt && (cur_tt & 9'h1F0) == 9'h040) && nt != m_tt) begin
        m_req = 1'b1; m_tt = nt;
      end
    end else if (m_req) begin
      m_req = 1'b0; m_tt = '0;
    end
  endtask

  task automatic check(string r, logic er, logic [8:0] et);
    n_chk++;
    if (req !== er || tt !== et) begin
      n_fail++;
      $display("FAIL %s: req=%0b tt=%h expected req=%0b tt=%h", r, req, tt, er, et);
    end
  endtask

  // inputs set at negedge; result due after one posedge, sampled at next negedge
  task automatic step(string r, logic [15:0] l, logic [16:0] s, logic [3:0] p,
                      logic en, logic b, logic [2:0] t, logic [8:0] ct);
    lvl_req = l; softint = s; pil = p; int_en = en; busy = b; tl = t; cur_tt = ct;
    model_step();
    @(posedge clk);
    @(negedge clk);
    check(r, m_req, m_tt);
  endtask

  // directed step with explicit expectation as well
  task automatic dstep(string r, logic [15:0] l, logic [16:0] s, logic [3:0] p,
                       logic en, logic b, logic [2:0] t, logic [8:0] ct,
                       logic er, logic [8:0] et);
    step(r, l, s, p, en, b, t, ct);
    check(r, er, et);
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    @(negedge clk);
    @(negedge clk);
    check("R1", 1'b0, 9'h000);
    rst_ni = 1'b1;
    @(negedge clk);
    // R6: single level, then two levels
    dstep("R6", 16'h0020, '0, 4'd0, 1, 0, 0, 0, 1'b1, 9'h045);
    dstep("R6", 16'h0208, '0, 4'd0, 1, 0, 0, 0, 1'b1, 9'h049);
    // R8: same type holds; higher level replaces
    dstep("R8", 16'h0208, '0, 4'd0, 1, 0, 0, 0, 1'b1, 9'h049);
    dstep("R8", 16'h1208, '0, 4'd0, 1, 0, 0, 0, 1'b1, 9'h04C);
    // R5: nothing above priority clears
    dstep("R5", 16'h1208, '0, 4'd12, 1, 0, 0, 0, 1'b0, 9'h000);
    // R3: each timer bit alone gives level 14
    dstep("R3", '0, 17'h00001, 4'd0, 1, 0, 0, 0, 1'b1, 9'h04E);
    dstep("R9", '0, 17'h00001, 4'd0, 0, 0, 0, 0, 1'b0, 9'h000);
    dstep("R3", '0, 17'h10000, 4'd0, 1, 0, 0, 0, 1'b1, 9'h04E);
    // R2: plain softint level; timer bit with priority 14 gives nothing
    dstep("R2", '0, 17'h00080, 4'd0, 1, 0, 0, 0, 1'b1, 9'h047);
    dstep("R2", '0, 17'h10001, 4'd14, 1, 0, 0, 0, 1'b0, 9'h000);
    // R4: vectored pending freezes outputs in both states
    dstep("R4", 16'h0004, '0, 4'd0, 1, 0, 0, 0, 1'b1, 9'h042);
    dstep("R4", 16'h8000, '0, 4'd0, 1, 1, 0, 0, 1'b1, 9'h042);
    dstep("R4", 16'h0000, '0, 4'd0, 0, 1, 0, 0, 1'b1, 9'h042);
    dstep("R5", 16'h0000, '0, 4'd0, 1, 0, 0, 0, 1'b0, 9'h000);
    // R7: nested higher ext type suppresses; other class or tl=0 does not
    dstep("R7", 16'h0020, '0, 4'd0, 1, 0, 3'd1, 9'h04C, 1'b0, 9'h000);
    dstep("R7", 16'h0020, '0, 4'd0, 1, 0, 3'd1, 9'h08C, 1'b1, 9'h045);
    dstep("R7", 16'h0020, '0, 4'd0, 0, 0, 3'd0, 9'h000, 1'b0, 9'h000);
    dstep("R7", 16'h0020, '0, 4'd0, 1, 0, 3'd0, 9'h04C, 1'b1, 9'h045);
    dstep("R7", 16'h0040, '0, 4'd0, 1, 0, 3'd2, 9'h04F, 1'b1, 9'h045);
    // R5: priority 15 always clears
    dstep("R5", 16'hFFFF, 17'h1FFFF, 4'd15, 1, 0, 0, 0, 1'b0, 9'h000);
    // R10: random mix checked against model
    for (int k = 0; k < 3000; k++) begin
      logic [15:0] l;
      logic [16:0] s;
      logic [8:0]  ct;
      l  = 16'($urandom) & 16'($urandom) & 16'($urandom);
      s  = 17'($urandom) & 17'($urandom) & 17'($urandom);
      ct = ($urandom % 2) ? (9'h040 | 9'($urandom % 16)) : 9'($urandom);
      step("R10", l, s, 4'($urandom), ($urandom % 8) != 0, ($urandom % 8) == 0,
           ($urandom % 2) ? 3'($urandom) : 3'd0, ct);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not complete");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule